// File: doc/BRIEF.md
# Serial-Clocked Wiper Step Unit

This unit carries out the stepping mode of a four-channel digital potentiometer controller. Once the serial front end has acknowledged the step opcode, it raises `arm` for one clock and gives the channel to adjust on `arm_sel`. From then on there is no data byte. Every clock pulse on the two-wire bus is a step command for the selected wiper. The level of the data line decides the direction of each step.

The unit watches the raw bus lines through its own synchronizers. It samples the data level when the serial clock rises and applies the step when the serial clock falls. A change on the data line while the serial clock is high is a bus START or STOP condition. Such a change ends the mode and does not step the wiper. Each wiper holds one of 64 positions and stops at either end instead of wrapping. The unit changes only the volatile wiper positions. It never drives the data line and never starts a retained-memory programming cycle.

Top module: `wiper_step_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `step_active` is 0 and every wiper field of `wiper_pos` equals RESET_POS (default 32).
- R2: A one-cycle `arm` pulse sets `step_active` to 1 and selects channel `arm_sel`. Steps then change only field `arm_sel` of `wiper_pos`, where field i is bits [i*6+5 : i*6].
- R3: With the mode active, a serial clock high pulse during which the data line stays high adds 1 to the selected wiper. The new value is visible within 8 clocks after the serial clock falls.
- R4: With the mode active, a serial clock high pulse during which the data line stays low subtracts 1 from the selected wiper.
- R5: Positions saturate. An up step at 63 leaves the wiper at 63, and a down step at 0 leaves it at 0. A wiper never changes by more than one position per step.
- R6: A data-line rise (STOP) or fall (START) while the serial clock is high clears `step_active`, and that clock pulse causes no step.
- R7: Serial clock pulses while `step_active` is 0 leave every wiper unchanged.
- R8: Any number and any mix of up and down steps may follow one `arm`. Each step acts on the position left by the step before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line level |
| arm | input | 1 | One-cycle pulse from the front end: step opcode acknowledged |
| arm_sel | input | 2 | Channel to step, valid with `arm` |
| step_active | output | 1 | Stepping mode is in effect |
| wiper_pos | output | 24 | Four 6-bit wiper positions, channel 0 in the low bits |

## Verification
A wrong direction latch or a missed edge shows at the port within eight clocks of the serial clock falling. The affected wiper field moves the wrong way, moves twice, or does not move. A broken saturation guard shows at once as a jump between 63 and 0. A mode flag that does not clear on START or STOP shows on the next clock pulse, which moves a wiper that should stay fixed. A wrong channel decode shows as a change in a field other than the selected one.

// File: rtl/wstep_pkg.sv
package wstep_pkg;

  // Internal stepping state of the mode controller.
  typedef enum logic [1:0] {
    ST_OFF       = 2'd0,
    ST_WAIT_RISE = 2'd1,
    ST_WAIT_FALL = 2'd2
  } wstep_state_e;

  // Direction carried with a committed step.
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } wstep_dir_e;

endpackage

// File: rtl/wstep_busmon.sv
// Synchronises the raw bus lines and flags clock edges and bus conditions.
module wstep_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop,
  output logic sda_lvl
);

  logic [SYNC_STAGES-1:0] scl_sh;
  logic [SYNC_STAGES-1:0] sda_sh;
  logic                   scl_q;
  logic                   sda_q;
  logic                   scl_s;
  logic                   sda_s;

  // Idle bus is high on both lines.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
  assign sda_lvl   = sda_s;

endmodule

// File: rtl/wstep_ctrl.sv
// Mode controller: latches direction on clock rise, commits on clock fall.
module wstep_ctrl
  import wstep_pkg::*;
#(
  parameter int NCH = 4,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [SEL_W-1:0] arm_sel,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             sda_lvl,
  output logic             active,
  output logic             step_vld,
  output logic             step_up,
  output logic [SEL_W-1:0] step_ch
);

  wstep_state_e state_q;
  wstep_dir_e   dir_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OFF;
      dir_q    <= DIR_DOWN;
      sel_q    <= '0;
      active   <= 1'b0;
      step_vld <= 1'b0;
      step_up  <= 1'b0;
      step_ch  <= '0;
    end else begin
      step_vld <= 1'b0;
      if (bus_start || bus_stop) begin
        // A bus condition ends the mode and discards the pending step.
        state_q <= ST_OFF;
        active  <= 1'b0;
      end else if (arm) begin
        state_q <= ST_WAIT_RISE;
        sel_q   <= arm_sel;
        active  <= 1'b1;
      end else begin
        unique case (state_q)
          ST_WAIT_RISE: begin
            if (scl_rise) begin
              dir_q   <= sda_lvl ? DIR_UP : DIR_DOWN;
              state_q <= ST_WAIT_FALL;
            end
          end
          ST_WAIT_FALL: begin
            if (scl_fall) begin
              step_vld <= 1'b1;
              step_up  <= (dir_q == DIR_UP);
              step_ch  <= sel_q;
              state_q  <= ST_WAIT_RISE;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/wstep_bank.sv
// Volatile wiper positions, one saturating up/down register per channel.
module wstep_bank #(
  parameter int NCH       = 4,
  parameter int POS_W     = 6,
  parameter int RESET_POS = 32,
  localparam int SEL_W    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_vld,
  input  logic                 step_up,
  input  logic [SEL_W-1:0]     step_ch,
  output logic [NCH*POS_W-1:0] pos_flat
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [POS_W-1:0] pos_q;
    logic             hit;

    assign hit = step_vld && (step_ch == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        pos_q <= POS_W'(RESET_POS);
      end else if (hit) begin
        if (step_up && (pos_q != POS_MAX)) begin
          pos_q <= pos_q + 1'b1;
        end else if (!step_up && (pos_q != '0)) begin
          pos_q <= pos_q - 1'b1;
        end
      end
    end

    assign pos_flat[i*POS_W +: POS_W] = pos_q;
  end

endmodule

// File: rtl/wiper_step_unit.sv
// Top: stepping mode for a bank of wiper registers driven from the serial bus.
module wiper_step_unit #(
  parameter int NCH         = 4,
  parameter int POS_W       = 6,
  parameter int RESET_POS   = 32,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_in,
  input  logic                 sda_in,
  input  logic                 arm,
  input  logic [SEL_W-1:0]     arm_sel,
  output logic                 step_active,
  output logic [NCH*POS_W-1:0] wiper_pos
);

  logic             scl_rise;
  logic             scl_fall;
  logic             bus_start;
  logic             bus_stop;
  logic             sda_lvl;
  logic             step_vld;
  logic             step_up;
  logic [SEL_W-1:0] step_ch;

  wstep_busmon #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_busmon (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .sda_lvl   (sda_lvl)
  );

  wstep_ctrl #(
    .NCH (NCH)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .arm_sel   (arm_sel),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .sda_lvl   (sda_lvl),
    .active    (step_active),
    .step_vld  (step_vld),
    .step_up   (step_up),
    .step_ch   (step_ch)
  );

  wstep_bank #(
    .NCH       (NCH),
    .POS_W     (POS_W),
    .RESET_POS (RESET_POS)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .step_vld (step_vld),
    .step_up  (step_up),
    .step_ch  (step_ch),
    .pos_flat (wiper_pos)
  );

endmodule

// File: rtl/wiper_step_unit_chk.sv
module wiper_step_unit_chk #(
  parameter int NCH   = 4,
  parameter int POS_W = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 step_active,
  input logic [NCH*POS_W-1:0] wiper_pos
);

  logic [NCH*POS_W-1:0] prev_pos;
  logic                 hist;
  logic [NCH-1:0]       moved;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= 1'b0;
    end else begin
      hist <= 1'b1;
    end
    prev_pos <= wiper_pos;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_mv
    logic [POS_W:0] cur_x;
    logic [POS_W:0] old_x;
    assign cur_x    = {1'b0, wiper_pos[i*POS_W +: POS_W]};
    assign old_x    = {1'b0, prev_pos[i*POS_W +: POS_W]};
    assign moved[i] = hist && (cur_x != old_x);

    // R5
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
      moved[i] |-> ((cur_x == old_x + 1'b1) || (cur_x + 1'b1 == old_x)));
  end

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    rst |=> !step_active);

  // R2
  single_channel_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(moved) <= 1);

  // R7
  active_only_chk: assert property (@(posedge clk) disable iff (rst)
    (moved != '0) |-> $past(step_active));

endmodule

bind wiper_step_unit wiper_step_unit_chk #(
  .NCH   (NCH),
  .POS_W (POS_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .step_active (step_active),
  .wiper_pos   (wiper_pos)
);

// File: tb/wiper_step_unit_tb.sv
module wiper_step_unit_tb;

  localparam int NCH   = 4;
  localparam int POS_W = 6;
  localparam int RPOS  = 32;
  localparam int PMAX  = 63;
  localparam int HALF  = 8;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 scl_in = 1'b1;
  logic                 sda_in = 1'b1;
  logic                 arm = 1'b0;
  logic [1:0]           arm_sel = '0;
  logic                 step_active;
  logic [NCH*POS_W-1:0] wiper_pos;

  int checks = 0;
  int errors = 0;
  int exp_pos[NCH];
  bit done = 0;

  always #2.5 clk = ~clk;

  wiper_step_unit #(
    .NCH   (NCH),
    .POS_W (POS_W)
  ) u_dut (
    .clk         (clk),
    .rst         (rst),
    .scl_in      (scl_in),
    .sda_in      (sda_in),
    .arm         (arm),
    .arm_sel     (arm_sel),
    .step_active (step_active),
    .wiper_pos   (wiper_pos)
  );

  task automatic wait_clk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check_pos(input string req);
    for (int c = 0; c < NCH; c++) begin
      int act;
      act = int'(wiper_pos[c*POS_W +: POS_W]);
      checks++;
      if (act != exp_pos[c]) begin
        errors++;
        $display("FAIL %s ch%0d pos actual %0d expected %0d", req, c, act, exp_pos[c]);
      end
    end
  endtask

  task automatic check_active(input string req, input logic e);
    checks++;
    if (step_active !== e) begin
      errors++;
      $display("FAIL %s step_active actual %0b expected %0b", req, step_active, e);
    end
  endtask

  // One serial clock pulse with the data line held at d.
  task automatic pulse(input logic d);
    sda_in = d;
    wait_clk(HALF);
    scl_in = 1'b1;
    wait_clk(HALF);
    scl_in = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic model_step(input int ch, input logic up);
    if (up && exp_pos[ch] < PMAX) exp_pos[ch]++;
    else if (!up && exp_pos[ch] > 0) exp_pos[ch]--;
  endtask

  task automatic do_arm(input int ch);
    arm_sel = 2'(ch);
    arm = 1'b1;
    wait_clk(1);
    arm = 1'b0;
    wait_clk(2);
  endtask

  task automatic bus_stop_cond();
    sda_in = 1'b0;
    wait_clk(HALF);
    scl_in = 1'b1;
    wait_clk(HALF);
    sda_in = 1'b1;
    wait_clk(HALF);
    scl_in = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic bus_start_cond();
    sda_in = 1'b1;
    wait_clk(HALF);
    scl_in = 1'b1;
    wait_clk(HALF);
    sda_in = 1'b0;
    wait_clk(HALF);
    scl_in = 1'b0;
    wait_clk(HALF);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) exp_pos[c] = RPOS;
    wait_clk(4);
    // R1: state while held in reset
    check_active("R1", 1'b0);
    check_pos("R1");
    rst = 1'b0;
    wait_clk(1);
    check_active("R1", 1'b0);
    check_pos("R1");
    scl_in = 1'b0;
    wait_clk(HALF);

    // R7: pulses before any arm do nothing
    pulse(1'b1);
    pulse(1'b0);
    check_pos("R7");

    for (int ch = 0; ch < NCH; ch++) begin
      do_arm(ch);
      check_active("R2", 1'b1);
      // R3 and R5: climb past the top
      for (int k = 0; k < 40; k++) begin
        pulse(1'b1);
        model_step(ch, 1'b1);
        check_pos("R3");
      end
      // R4 and R5: fall past the bottom
      for (int k = 0; k < 70; k++) begin
        pulse(1'b0);
        model_step(ch, 1'b0);
        check_pos("R4");
      end
      // R8: mixed directions in the same transfer
      for (int k = 0; k < 24; k++) begin
        logic up;
        up = (((k * (ch + 1)) + k) % 3) != 0;
        pulse(up);
        model_step(ch, up);
        check_pos("R8");
      end
      // R6: alternate STOP and START to end the mode
      if (ch % 2 == 0) bus_stop_cond();
      else bus_start_cond();
      check_active("R6", 1'b0);
      check_pos("R6");
      // R7: pulses after the mode has ended move nothing
      pulse(1'b1);
      pulse(1'b0);
      check_pos("R7");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    wait_clk(200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule